// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block masters a parallel bus toward a display panel. Software loads 32-bit words into an eight-word write queue. The engine slices each word into 8-bit or 16-bit picks, lowest pick first, and puts them on the bus as a programmed number of bus cycles. Each cycle has a strobe-low phase and a strobe-high recovery phase. Both are counted in ticks of the functional clock divided by a value from one to eight. A chip-select level and a command/data level come straight from a configuration register. The same timing also runs read cycles: the returned picks are packed back into words and queued in an eight-word read queue.

Software reaches the block through one small register port with four word addresses. Address 0 is the timing and transfer register. Address 1 is the control register. Address 2 sets the pick format and the divider. Address 3 is the queue window: a write pushes to the write queue and a read returns the head of the read queue. A request output stays high while the write queue has room, so a feeder can keep the queue topped up. A status bit reports when every queued write has left the bus.

Top module: `pdb_engine`

## Requirements
- R1: After reset, register 0 reads 0x42000000, register 1 reads 0x18 (hold bit 4 set, done bit 3 set), and register 2 reads 0x67. Chip select, write strobe and read strobe are all high, and the request output is high.
- R2: A write to register 0 loads a transfer of (bits 17:0 + 1) bus cycles. Cycles launch only while enable (register 1 bit 0) is 1, bit 30 of register 0 is 0, and hold (register 1 bit 4) is 0.
- R3: In each cycle the strobe stays low for (bits 23:20 of register 0 + 1) ticks.
- R4: Between back-to-back cycles the strobe stays high for (bits 29:24 of register 0 + 1) ticks. Writing register 0 with bits 29:24 below 2 discards the write, restores all three registers to their reset values, and empties both queues.
- R5: One tick lasts (bits 12:10 of register 2 + 1) clocks.
- R6: Bit 3 of the width field (register 2 bits 4:0) selects 16-bit picks when 1 (programmed value 15) and 8-bit picks when 0 (programmed value 7). An 8-bit pick appears on the low byte of the data output with the high byte zero. The count field (register 2 bits 6:5) holds picks per word minus one. Picks go out least significant first, and a word is retired after its last pick.
- R7: The chip select output follows bit 30 of register 0, and the command/data output follows bit 18.
- R8: With register 1 bit 5 set, cycles drive the read strobe instead. The data input is captured one tick after the read strobe rises and packed least significant first. A word is queued after its last pick or after the last cycle of the transfer. Reading address 3 returns the head word, and regRe pops it.
- R9: An empty write queue pauses the sequence between cycles with the strobe high. The sequence resumes when a word arrives.
- R10: Register 1 bit 3 reads 1 exactly when the write queue is empty and no cycle is in progress.
- R11: The request output is high while the write queue holds fewer than 8 words. A push to a full queue is dropped.
- R12: While register 1 bit 1 is set, both queues are emptied and no cycle runs. With enable at 0, no cycle launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe; pops the read queue at address 3 |
| regAddr | input | 2 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| busDin | input | 16 | Data returned by the panel |
| busCsN | output | 1 | Chip select, active low |
| busWrN | output | 1 | Write strobe, active low |
| busRdN | output | 1 | Read strobe, active low |
| busCd | output | 1 | Command (0) or data (1) select |
| busDout | output | 16 | Data driven to the panel |
| dmaReq | output | 1 | Write queue has room |

## Verification
The bench keeps a behavioural model of the register levels and a queue of expected bus picks. It also measures every strobe-low and strobe-high interval in clocks. Byte transfers with the divider at one separate pick order from strobe and recovery widths. A 16-bit transfer with a divide of three shows whether the durations scale by the tick. Starving the write queue mid-transfer, overfilling it, and running a read transfer whose length is not a multiple of the word size cover the stall, the dropped push and the partial-word flush. An illegal recovery write and a soft reset show whether configuration and queue contents really return to their reset state.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_ACTIVE, ST_RECOV} busState_e;

  typedef struct packed {
    logic launch;     // a new bus cycle starts on this clock
    logic sample;     // first recovery tick edge after the strobe rose
    logic lastCycle;  // the cycle in flight is the final one of the transfer
    logic idle;       // no cycle in progress
    logic strobeLow;  // strobe-active phase
  } ctrlStrobe_t;

  localparam logic [31:0] CFG_A_RST = 32'h4200_0000;
  localparam logic [31:0] CFG_B_RST = 32'h0000_0010;
  localparam logic [31:0] CFG_C_RST = 32'h0000_0067;
  localparam logic [31:0] CFG_B_MASK = 32'h0000_0033;
  localparam logic [31:0] CFG_C_MASK = 32'h0000_1FFF;
endpackage

// File: rtl/pdb_ctrl.sv
module pdb_ctrl
  import pdb_pkg::*;
#(
  parameter int CYC_W = 18,
  parameter int TW0_W = 4,
  parameter int TW1_W = 6,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engRst,
  input  logic             enable,
  input  logic             csN,
  input  logic             weHold,
  input  logic             dataReady,
  input  logic             loadCycles,
  input  logic [CYC_W-1:0] loadVal,
  input  logic [TW0_W-1:0] tw0,
  input  logic [TW1_W-1:0] tw1,
  input  logic [DIV_W-1:0] divSel,
  output ctrlStrobe_t      strb
);
  localparam int CNT_W = (TW1_W > TW0_W) ? TW1_W : TW0_W;

  busState_e        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [DIV_W-1:0] divCnt;
  logic [CYC_W:0]   cyclesLeft;
  logic             tick, go, goNext, recovEnd, allowed;

  assign tick     = (divCnt >= divSel);
  assign allowed  = enable && !csN && !weHold && dataReady;
  assign go       = allowed && (cyclesLeft != '0);
  assign goNext   = allowed && (cyclesLeft > (CYC_W+1)'(1));
  assign recovEnd = (state == ST_RECOV) && (phaseCnt == CNT_W'(tw1 - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; phaseCnt <= '0; divCnt <= '0; cyclesLeft <= '0;
    end else if (engRst) begin
      state <= ST_IDLE; phaseCnt <= '0; divCnt <= '0; cyclesLeft <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (loadCycles) cyclesLeft <= {1'b0, loadVal} + 1'b1;
      else if (tick && recovEnd) cyclesLeft <= cyclesLeft - 1'b1;
      if (tick) begin
        case (state)
          ST_IDLE:   if (go) state <= ST_LEAD;
          ST_LEAD:   begin state <= ST_ACTIVE; phaseCnt <= '0; end
          ST_ACTIVE: begin
            if (phaseCnt == CNT_W'(tw0)) begin state <= ST_RECOV; phaseCnt <= '0; end
            else phaseCnt <= phaseCnt + 1'b1;
          end
          ST_RECOV: begin
            if (recovEnd) state <= goNext ? ST_LEAD : ST_IDLE;
            else phaseCnt <= phaseCnt + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb.launch    = tick && (((state == ST_IDLE) && go) || (recovEnd && goNext));
    strb.sample    = tick && (state == ST_RECOV) && (phaseCnt == '0);
    strb.lastCycle = (cyclesLeft == (CYC_W+1)'(1));
    strb.idle      = (state == ST_IDLE);
    strb.strobeLow = (state == ST_ACTIVE);
  end

  // R4: the datapath must never hand over a recovery below three ticks
  a_r4_recov_legal: assert property (@(posedge clk) disable iff (!rstN)
    tw1 >= TW1_W'(2));
  // R2: a cycle in progress always belongs to a transfer with cycles left
  a_r2_count_live: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (cyclesLeft != '0));
  // R5: with a stable divider above one, ticks never fall on adjacent clocks
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divSel != '0) |=> (!tick || divSel != $past(divSel)));
endmodule

// File: rtl/pdb_datapath.sv
module pdb_datapath
  import pdb_pkg::*;
#(
  parameter int CYC_W      = 18,
  parameter int TW0_W      = 4,
  parameter int TW1_W      = 6,
  parameter int DIV_W      = 3,
  parameter int BUS_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [BUS_W-1:0] busDin,
  output logic             busCsN,
  output logic             busWrN,
  output logic             busRdN,
  output logic             busCd,
  output logic [BUS_W-1:0] busDout,
  output logic             dmaReq,
  output logic             engRst,
  output logic             enable,
  output logic             csN,
  output logic             weHold,
  output logic             dataReady,
  output logic             loadCycles,
  output logic [CYC_W-1:0] loadVal,
  output logic [TW0_W-1:0] tw0,
  output logic [TW1_W-1:0] tw1,
  output logic [DIV_W-1:0] divSel,
  input  ctrlStrobe_t      strb
);
  localparam int WORD_W   = 32;
  localparam int NARROW_W = BUS_W / 2;
  localparam int PICK_W   = $clog2(WORD_W / NARROW_W);
  localparam int PTR_W    = $clog2(FIFO_DEPTH);
  localparam logic [PTR_W:0] FULL = (PTR_W+1)'(FIFO_DEPTH);

  logic [31:0] cfgA, cfgB, cfgC;
  logic        selfRst, badTiming, rdMode, wide, lastPick, writesDone;
  logic [PICK_W-1:0] pickIdx;
  logic [WORD_W-1:0] wrMem [FIFO_DEPTH];
  logic [WORD_W-1:0] rdMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrHd, wrTl, rdHd, rdTl;
  logic [PTR_W:0]    wrCnt, rdCnt;
  logic              wrPush, wrPop, rdPush, rdPop, pickAdv;
  logic [WORD_W-1:0] rdAsm, rdAsmNext, wrHead;

  // Configuration registers and the self-reset on an illegal recovery
  assign badTiming = regWe && (regAddr == 2'd0) && (regWdata[29:24] < 6'd2);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgA <= CFG_A_RST; cfgB <= CFG_B_RST; cfgC <= CFG_C_RST; selfRst <= 1'b0;
    end else begin
      selfRst <= badTiming;
      if (selfRst) begin
        cfgA <= CFG_A_RST; cfgB <= CFG_B_RST; cfgC <= CFG_C_RST;
      end else if (regWe) begin
        case (regAddr)
          2'd0: if (!badTiming) cfgA <= regWdata;
          2'd1: cfgB <= regWdata & CFG_B_MASK;
          2'd2: cfgC <= regWdata & CFG_C_MASK;
          default: ;
        endcase
      end
    end
  end

  assign engRst     = cfgB[1] || selfRst;
  assign enable     = cfgB[0];
  assign weHold     = cfgB[4];
  assign rdMode     = cfgB[5];
  assign csN        = cfgA[30];
  assign tw0        = cfgA[23:20];
  assign tw1        = cfgA[29:24];
  assign divSel     = cfgC[12:10];
  assign wide       = cfgC[3];
  assign loadCycles = regWe && (regAddr == 2'd0) && !badTiming && !selfRst;
  assign loadVal    = regWdata[CYC_W-1:0];
  assign lastPick   = (pickIdx == cfgC[5 +: PICK_W]);

  // Queue control
  assign wrPush   = regWe && (regAddr == 2'd3) && (wrCnt < FULL) && !engRst;
  assign wrPop    = strb.launch && !rdMode && lastPick;
  assign rdPush   = strb.sample && rdMode && (lastPick || strb.lastCycle);
  assign rdPop    = regRe && (regAddr == 2'd3) && (rdCnt != '0);
  assign pickAdv  = rdMode ? strb.sample : strb.launch;
  assign wrHead   = wrMem[wrHd];
  assign dataReady = rdMode ? (rdCnt < FULL) : (wrCnt != '0);
  assign dmaReq   = wrCnt < FULL;
  assign writesDone = (wrCnt == '0) && strb.idle;

  always_ff @(posedge clk) begin
    if (wrPush) wrMem[wrTl] <= regWdata;
    if (rdPush) rdMem[rdTl] <= rdAsmNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrHd <= '0; wrTl <= '0; wrCnt <= '0; rdHd <= '0; rdTl <= '0; rdCnt <= '0;
    end else if (engRst) begin
      wrHd <= '0; wrTl <= '0; wrCnt <= '0; rdHd <= '0; rdTl <= '0; rdCnt <= '0;
    end else begin
      if (wrPush) wrTl <= wrTl + 1'b1;
      if (wrPop)  wrHd <= wrHd + 1'b1;
      wrCnt <= wrCnt + (PTR_W+1)'(wrPush) - (PTR_W+1)'(wrPop);
      if (rdPush) rdTl <= rdTl + 1'b1;
      if (rdPop)  rdHd <= rdHd + 1'b1;
      rdCnt <= rdCnt + (PTR_W+1)'(rdPush) - (PTR_W+1)'(rdPop);
    end
  end

  // Pick sequencing, output lane and read packing
  always_comb begin
    rdAsmNext = rdAsm;
    if (wide) rdAsmNext[int'(pickIdx[0]) * BUS_W +: BUS_W] = busDin;
    else      rdAsmNext[int'(pickIdx) * NARROW_W +: NARROW_W] = busDin[NARROW_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pickIdx <= '0; rdAsm <= '0; busDout <= '0;
    end else if (engRst || loadCycles) begin
      pickIdx <= '0; rdAsm <= '0;
      if (engRst) busDout <= '0;
    end else begin
      if (pickAdv) begin
        if (lastPick || (rdMode && strb.lastCycle)) pickIdx <= '0;
        else pickIdx <= pickIdx + 1'b1;
      end
      if (strb.sample && rdMode) rdAsm <= rdPush ? '0 : rdAsmNext;
      if (strb.launch && !rdMode) begin
        if (wide) busDout <= wrHead[int'(pickIdx[0]) * BUS_W +: BUS_W];
        else      busDout <= {{(BUS_W-NARROW_W){1'b0}}, wrHead[int'(pickIdx) * NARROW_W +: NARROW_W]};
      end
    end
  end

  assign busWrN = !(strb.strobeLow && !rdMode);
  assign busRdN = !(strb.strobeLow && rdMode);
  assign busCsN = cfgA[30];
  assign busCd  = cfgA[18];

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = cfgA;
      2'd1:    regRdata = cfgB | {28'd0, writesDone, 3'd0};
      2'd2:    regRdata = cfgC;
      default: regRdata = rdMem[rdHd];
    endcase
  end

  // R11: a word is retired only when the control launches into a filled queue
  a_r11_no_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    wrPop |-> (wrCnt != '0));
  // R8: a packed read word never lands in a full read queue
  a_r8_rd_room: assert property (@(posedge clk) disable iff (!rstN)
    rdPush |-> (rdCnt < FULL));
  // R10: reported completion means both strobes are idle
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    writesDone |-> (busWrN && busRdN));
  // R12: soft reset leaves no cycle running on the following clock
  a_r12_soft_halt: assert property (@(posedge clk) disable iff (!rstN)
    cfgB[1] |=> strb.idle);
endmodule

// File: rtl/pdb_engine.sv
module pdb_engine
  import pdb_pkg::*;
#(
  parameter int CYC_W      = 18,
  parameter int TW0_W      = 4,
  parameter int TW1_W      = 6,
  parameter int DIV_W      = 3,
  parameter int BUS_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [BUS_W-1:0] busDin,
  output logic             busCsN,
  output logic             busWrN,
  output logic             busRdN,
  output logic             busCd,
  output logic [BUS_W-1:0] busDout,
  output logic             dmaReq
);
  ctrlStrobe_t      strb;
  logic             engRst, enable, csN, weHold, dataReady, loadCycles;
  logic [CYC_W-1:0] loadVal;
  logic [TW0_W-1:0] tw0;
  logic [TW1_W-1:0] tw1;
  logic [DIV_W-1:0] divSel;

  pdb_datapath #(
    .CYC_W(CYC_W), .TW0_W(TW0_W), .TW1_W(TW1_W), .DIV_W(DIV_W),
    .BUS_W(BUS_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busDin(busDin),
    .busCsN(busCsN), .busWrN(busWrN), .busRdN(busRdN), .busCd(busCd),
    .busDout(busDout), .dmaReq(dmaReq), .engRst(engRst), .enable(enable),
    .csN(csN), .weHold(weHold), .dataReady(dataReady), .loadCycles(loadCycles),
    .loadVal(loadVal), .tw0(tw0), .tw1(tw1), .divSel(divSel), .strb(strb)
  );

  pdb_ctrl #(
    .CYC_W(CYC_W), .TW0_W(TW0_W), .TW1_W(TW1_W), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .engRst(engRst), .enable(enable), .csN(csN),
    .weHold(weHold), .dataReady(dataReady), .loadCycles(loadCycles),
    .loadVal(loadVal), .tw0(tw0), .tw1(tw1), .divSel(divSel), .strb(strb)
  );
endmodule

// File: tb/pdb_engine_bench.sv
module pdb_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] busDin = '0;
  logic        busCsN, busWrN, busRdN, busCd, dmaReq;
  logic [15:0] busDout;

  pdb_engine u_pdb_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busDin(busDin), .busCsN(busCsN),
    .busWrN(busWrN), .busRdN(busRdN), .busCd(busCd), .busDout(busDout), .dmaReq(dmaReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, wdog = 0;
  int nWr = 0, nRd = 0, lastFall = 0, lastRise = -1, expLow = 2, expHigh = 0;
  logic modelCs = 1'b1, modelCd = 1'b0, prevWrN = 1'b1, prevRdN = 1'b1;
  logic [15:0] expData[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: register levels and bus intervals, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk("R7 chip select", {31'd0, busCsN}, {31'd0, modelCs});
      chk("R7 command/data", {31'd0, busCd}, {31'd0, modelCd});
      if (prevWrN && !busWrN) begin
        nWr++;
        if (expData.size() == 0) chk("R2 unexpected write cycle", 32'd1, 32'd0);
        else chk("R6 pick data", {16'd0, busDout}, {16'd0, expData.pop_front()});
        if (expHigh != 0 && lastRise >= 0) chk("R4 recovery clocks", cyc - lastRise, expHigh);
        lastFall = cyc;
      end
      if (!prevWrN && busWrN) begin
        chk("R3 R5 strobe low clocks", cyc - lastFall, expLow);
        lastRise = cyc;
      end
      if (prevRdN && !busRdN) begin
        busDin = 16'h00A0 + 16'(nRd);
        nRd++;
        lastFall = cyc;
      end
      if (!prevRdN && busRdN) chk("R8 read strobe low clocks", cyc - lastFall, expLow);
    end
    prevWrN = busWrN;
    prevRdN = busRdN;
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", wdog, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic bad;
    bad = (a == 2'd0) && (d[29:24] < 6'd2);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    if (a == 2'd0 && !bad) begin modelCs = d[30]; modelCd = d[18]; end
    @(negedge clk);
    regWe = 1'b0;
    if (bad) begin
      @(posedge clk);
      modelCs = 1'b1; modelCd = 1'b0;
    end
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic popRd(output logic [31:0] v);
    @(negedge clk);
    regAddr = 2'd3; regRe = 1'b1;
    #1 v = regRdata;
    @(posedge clk);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 3000; i++) begin
      rdReg(2'd1, v);
      if (v[3]) break;
    end
    chk("R10 writes done", {31'd0, v[3]}, 32'd1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdReg(2'd0, v); chk("R1 reg0 reset", v, 32'h4200_0000);
    rdReg(2'd1, v); chk("R1 reg1 reset", v, 32'h0000_0018);
    rdReg(2'd2, v); chk("R1 reg2 reset", v, 32'h0000_0067);
    chk("R1 strobes idle", {30'd0, busWrN, busRdN}, 32'd3);
    chk("R1 request high", {31'd0, dmaReq}, 32'd1);

    // R2 R6: byte picks, one clock per tick
    expLow = 2; expHigh = 3; lastRise = -1; nWr = 0;
    wr(2'd3, 32'h4433_2211); wr(2'd3, 32'h8877_6655);
    for (int b = 1; b <= 8; b++) expData.push_back(16'(8'h11 * b));
    wr(2'd0, 32'h0214_0007);
    wr(2'd1, 32'h0000_0001);
    rdReg(2'd1, v); chk("R10 busy mid transfer", {31'd0, v[3]}, 32'd0);
    waitDone();
    chk("R2 cycle count", nWr, 8);

    // R5 R6: halfword picks, divide by three
    wr(2'd2, 32'h0000_082F);
    expLow = 12; expHigh = 15; lastRise = -1; nWr = 0;
    wr(2'd3, 32'hDDCC_BBAA); wr(2'd3, 32'h4433_2211);
    expData.push_back(16'hBBAA); expData.push_back(16'hDDCC);
    expData.push_back(16'h2211); expData.push_back(16'h4433);
    wr(2'd0, 32'h0430_0003);
    waitDone();
    chk("R5 halfword cycle count", nWr, 4);

    // R9: starved write queue
    wr(2'd2, 32'h0000_0067);
    expLow = 2; expHigh = 0; lastRise = -1; nWr = 0;
    wr(2'd0, 32'h0210_0007);
    repeat (40) @(negedge clk);
    chk("R9 no cycle while empty", nWr, 0);
    chk("R9 strobe high while empty", {31'd0, busWrN}, 32'd1);
    for (int b = 0; b < 4; b++) expData.push_back(16'h0A + 16'(b));
    wr(2'd3, 32'h0D0C_0B0A);
    repeat (60) @(negedge clk);
    chk("R9 paused after one word", nWr, 4);
    for (int b = 0; b < 4; b++) expData.push_back(16'h1A + 16'(b));
    wr(2'd3, 32'h1D1C_1B1A);
    waitDone();
    chk("R9 resumed count", nWr, 8);

    // R11: request and dropped push
    wr(2'd1, 32'h0000_0011);
    for (int k = 0; k < 9; k++) begin
      wr(2'd3, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
      if (k == 7) chk("R11 request low when full", {31'd0, dmaReq}, 32'd0);
    end
    for (int b = 0; b < 32; b++) expData.push_back(16'(b));
    expHigh = 3; lastRise = -1; nWr = 0;
    wr(2'd0, 32'h0210_001F);
    wr(2'd1, 32'h0000_0001);
    waitDone();
    chk("R11 ninth word dropped", nWr, 32);
    chk("R11 request high after drain", {31'd0, dmaReq}, 32'd1);

    // R8: read transfer with a partial last word
    nRd = 0;
    wr(2'd1, 32'h0000_0021);
    wr(2'd0, 32'h0210_0005);
    repeat (80) @(negedge clk);
    chk("R8 read cycle count", nRd, 6);
    popRd(v); chk("R8 first read word", v, 32'hA3A2_A1A0);
    popRd(v); chk("R8 partial read word", v, 32'h0000_A5A4);

    // R12: soft reset flush and enable gating
    wr(2'd1, 32'h0000_0010);
    wr(2'd3, 32'h1111_1111); wr(2'd3, 32'h2222_2222);
    rdReg(2'd1, v); chk("R10 queue loaded", {31'd0, v[3]}, 32'd0);
    wr(2'd1, 32'h0000_0012);
    wr(2'd1, 32'h0000_0000);
    rdReg(2'd1, v); chk("R12 soft reset flushed", {31'd0, v[3]}, 32'd1);
    nWr = 0; lastRise = -1;
    wr(2'd3, 32'h0403_0201);
    wr(2'd0, 32'h0210_0003);
    repeat (40) @(negedge clk);
    chk("R12 disabled no cycles", nWr, 0);
    for (int b = 1; b <= 4; b++) expData.push_back(16'(b));
    wr(2'd1, 32'h0000_0001);
    waitDone();
    chk("R12 enabled cycles", nWr, 4);

    // R4: illegal recovery triggers self reset
    wr(2'd1, 32'h0000_0011);
    for (int k = 0; k < 8; k++) wr(2'd3, 32'hCAFE_0000 + k);
    chk("R11 full before self reset", {31'd0, dmaReq}, 32'd0);
    wr(2'd0, 32'h0100_0000);
    repeat (2) @(negedge clk);
    rdReg(2'd0, v); chk("R4 reg0 restored", v, 32'h4200_0000);
    rdReg(2'd1, v); chk("R4 reg1 restored", v, 32'h0000_0018);
    rdReg(2'd2, v); chk("R4 reg2 restored", v, 32'h0000_0067);
    chk("R4 queue emptied", {31'd0, dmaReq}, 32'd1);
    chk("R2 no stray picks", expData.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule